// File: doc/BRIEF.md
# Masked vector lane unpacker

This block turns a stream of packed input beats into individual 32-bit lane writes for a four-lane (X, Y, Z, W) vector register. A command sets an element budget. Each accepted beat then yields up to four lane writes, one per clock cycle, issued in lane order. Each write carries its lane index. A write is taken from one of three sources: the element unpacked from the beat, a per-lane row constant, or a column constant chosen by the current write cycle.

A 2-bit code picks the source for each lane. The code comes from a 32-bit mask word, indexed by the lane and by the write cycle. Two arithmetic modes apply when the code selects data. Offset mode adds the lane's row constant to the element. Difference mode adds it too, then writes the sum back into the row constant so that it accumulates.

The block keeps a lane offset and a write-cycle counter from one command to the next. When a command runs out of elements partway through a vector, the next command resumes at the lane where it stopped.

The sequencer has three states:
- IDLE: waits for a command. `cmd_start` with a non-zero count moves to FETCH.
- FETCH: holds `in_ready` high. A beat with `in_valid` moves to EMIT.
- EMIT: processes one lane per cycle. After lane W it goes to FETCH if elements remain, or to IDLE if none do. Before any lane that needs an element when none remain, it goes to IDLE.

Top module: `vupack_mask`

## Requirements
- R1: The write cycle starts at 0. It advances by one each time lane W is processed and saturates at 3. The mask code for a lane is `mask_word[cycle*8 + lane*2 +: 2]`, with lane X=0, Y=1, Z=2, W=3. A start with `cmd_fresh`=1 clears both the cycle and the lane offset.
- R2: With `mask_en`=0 every lane uses code 0, whatever `mask_word` holds.
- R3: Code 0 writes the data value. Code 1 writes the lane's row constant. Code 2 writes column constant `col_regs[cycle*32 +: 32]`.
- R4: Under code 0 the result depends on `mode`. Mode 1 writes element + row. Mode 2 writes element + row and also stores that sum into the lane's row constant. Any other mode writes the element unchanged.
- R5: Width code 3 is packed colour, taken from beat bits [15:0]. It yields X={b[4:0],3'b0}, Y={b[9:5],3'b0}, Z={b[14:10],3'b0}, W={b[15],7'b0}, each zero-extended to 32 bits. Every lane consumes one count, and modes 1 and 2 have no effect.
- R6: The lane offset steps X→Y→Z→W and wraps to X. A command that runs out partway through a vector leaves the offset in place. A later start with `cmd_fresh`=0 resumes at that lane, taking element data from the new beat.
- R7: In pair shape, X and Y consume counts and Z and W do not. Z repeats element 0 and W repeats element 1. At 32 bits, W is 0 instead.
- R8: In triple shape, X, Y and Z consume counts. W takes element 3 of the same beat without consuming a count.
- R9: With `fmt[4]`=0, 16-bit and 8-bit elements are sign-extended. With `fmt[4]`=1 they are zero-extended.
- R10: Code 3 produces no strobe. The lane is still stepped over and still consumes a count where its shape requires one.
- R11: After reset, `in_ready` and `out_valid` are low and the row constants are zero. A start with count 0 produces nothing. `row_wr` loads all four row constants, but only while idle. A beat offered while `in_ready` is high is processed starting in the next cycle.
- R12: `fmt[3:2]` selects the shape: 0 scalar, 1 pair, 2 triple, 3 quad. `fmt[1:0]` selects the width: 0 is 32-bit, 1 is 16-bit, 2 is 8-bit. Element e sits at `in_data[e*w +: w]`. In scalar shape every lane uses element 0 and consumes one count. In quad shape lane n uses element n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 5 | Element format: unsigned flag, shape, width; hold stable during a command |
| mask_en | input | 1 | Enables mask codes |
| mode | input | 2 | 1 offset, 2 difference, others plain |
| mask_word | input | 32 | Four cycle bytes of 2-bit lane codes |
| col_regs | input | 128 | Column constants, cycle n at [n*32 +: 32] |
| row_wr | input | 1 | Load row constants (idle only) |
| row_wdata | input | 128 | Row constants to load, lane n at [n*32 +: 32] |
| cmd_start | input | 1 | Start a command (idle only) |
| cmd_fresh | input | 1 | With start: clear lane offset and write cycle |
| cmd_count | input | CNT_W | Element budget of the command |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts a beat |
| in_data | input | 128 | Packed input beat |
| out_valid | output | 1 | Lane write strobe |
| out_lane | output | 2 | Lane index of the write |
| out_data | output | 32 | Value written |

## Verification
The bench builds the block with CNT_W = 6, so a single command can carry up to 63 elements. That is enough for commands spanning five vectors, which drives the write cycle into saturation at 3 and reaches the fourth mask byte and the fourth column constant. The narrow count also keeps partial-vector stops and resumes within a few beats. Pair and triple runs are given budgets that end exactly on a consuming lane, so the non-consuming lanes appear both with the budget exhausted and with budget remaining.

// File: rtl/vu_pkg.sv
package vu_pkg;
    localparam int LANES  = 4;
    localparam int DW     = 32;
    localparam int BEAT_W = LANES * DW;

    typedef enum logic [1:0] {SHP_SCALAR = 2'd0, SHP_PAIR = 2'd1, SHP_TRIPLE = 2'd2, SHP_QUAD = 2'd3} shape_e;
    typedef enum logic [1:0] {WID_32 = 2'd0, WID_16 = 2'd1, WID_8 = 2'd2, WID_RGB = 2'd3} wid_e;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_FETCH = 2'd1, ST_EMIT = 2'd2} seq_state_e;

    localparam logic [1:0] MODE_OFFSET = 2'd1;
    localparam logic [1:0] MODE_DIFF   = 2'd2;

    // whether a lane slot draws on the element budget
    function automatic logic lane_consumes(shape_e s, wid_e w, logic [1:0] lane);
        logic r;
        if (w == WID_RGB) r = 1'b1;
        else begin
            unique case (s)
                SHP_PAIR:   r = (lane < 2'd2);
                SHP_TRIPLE: r = (lane < 2'd3);
                default:    r = 1'b1;
            endcase
        end
        return r;
    endfunction

    // which element of the beat feeds a lane
    function automatic logic [1:0] elem_index(shape_e s, logic [1:0] lane);
        logic [1:0] r;
        unique case (s)
            SHP_SCALAR: r = 2'd0;
            SHP_PAIR:   r = {1'b0, lane[0]};
            default:    r = lane;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/vu_seq.sv
module vu_seq import vu_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_fresh,
    input  logic [CNT_W-1:0] cmd_count,
    input  shape_e           shape,
    input  wid_e             wid,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             idle,
    output logic             emit,
    output logic             beat_load,
    output logic [1:0]       lane,
    output logic [1:0]       cyc
);
    seq_state_e       st_q, st_d;
    logic [1:0]       off_q, cyc_q;
    logic [CNT_W-1:0] rem_q, rem_after;
    logic             cons, next_cons, at_w;

    always_comb begin
        cons      = lane_consumes(shape, wid, off_q);
        next_cons = lane_consumes(shape, wid, off_q + 2'd1);
        rem_after = cons ? rem_q - 1'b1 : rem_q;
        at_w      = (off_q == 2'd3);
    end

    // next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (cmd_start && cmd_count != '0) st_d = ST_FETCH;
            ST_FETCH: if (in_valid) st_d = ST_EMIT;
            ST_EMIT: begin
                if (at_w)                                st_d = (rem_after == '0) ? ST_IDLE : ST_FETCH;
                else if (next_cons && rem_after == '0)   st_d = ST_IDLE;
                else                                     st_d = ST_EMIT;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // offset, write cycle and budget
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= 2'd0;
            cyc_q <= 2'd0;
            rem_q <= '0;
        end else if (st_q == ST_IDLE && cmd_start) begin
            rem_q <= cmd_count;
            if (cmd_fresh) begin
                off_q <= 2'd0;
                cyc_q <= 2'd0;
            end
        end else if (st_q == ST_EMIT) begin
            rem_q <= rem_after;
            off_q <= off_q + 2'd1;
            if (at_w && cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
        end
    end

    // outputs
    always_comb begin
        in_ready  = (st_q == ST_FETCH);
        idle      = (st_q == ST_IDLE);
        emit      = (st_q == ST_EMIT);
        beat_load = (st_q == ST_FETCH) && in_valid;
        lane      = off_q;
        cyc       = cyc_q;
    end

    assert_skip_keeps_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EMIT && !cons) |=> $stable(rem_q));
    assert_lane_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EMIT && off_q == 2'd3) |=> (off_q == 2'd0));
    assert_cycle_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EMIT && off_q == 2'd3 && cyc_q != 2'd3) |=> (cyc_q == $past(cyc_q) + 2'd1));
    assert_beat_to_emit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> emit);
endmodule

// File: rtl/vu_elem_extract.sv
module vu_elem_extract import vu_pkg::*; (
    input  logic [BEAT_W-1:0] beat,
    input  shape_e            shape,
    input  wid_e              wid,
    input  logic              is_unsigned,
    input  logic [1:0]        lane,
    output logic [DW-1:0]     elem
);
    logic [1:0]  idx;
    logic [15:0] h;
    logic [7:0]  b8;
    logic [15:0] rgb;

    always_comb begin
        idx  = elem_index(shape, lane);
        h    = beat[idx*16 +: 16];
        b8   = beat[idx*8 +: 8];
        rgb  = beat[15:0];
        elem = '0;
        unique case (wid)
            WID_32:  elem = (shape == SHP_PAIR && lane == 2'd3) ? '0 : beat[idx*DW +: DW];
            WID_16:  elem = is_unsigned ? {16'd0, h}  : {{16{h[15]}}, h};
            WID_8:   elem = is_unsigned ? {24'd0, b8} : {{24{b8[7]}}, b8};
            default: begin
                unique case (lane)
                    2'd0:    elem = {24'd0, rgb[4:0],   3'd0};
                    2'd1:    elem = {24'd0, rgb[9:5],   3'd0};
                    2'd2:    elem = {24'd0, rgb[14:10], 3'd0};
                    default: elem = {24'd0, rgb[15],    7'd0};
                endcase
            end
        endcase
    end
endmodule

// File: rtl/vu_lane_mux.sv
module vu_lane_mux import vu_pkg::*; (
    input  logic [DW-1:0]            elem,
    input  logic [1:0]               lane,
    input  logic [1:0]               cyc,
    input  logic                     mask_en,
    input  logic [31:0]              mask_word,
    input  logic [1:0]               mode,
    input  logic                     is_rgb,
    input  logic [LANES-1:0][DW-1:0] rows,
    input  logic [LANES-1:0][DW-1:0] cols,
    output logic [1:0]               code,
    output logic [DW-1:0]            value,
    output logic                     acc_we,
    output logic [DW-1:0]            acc_val
);
    logic [DW-1:0] sum;

    always_comb begin
        code    = mask_en ? mask_word[{cyc, lane, 1'b0} +: 2] : 2'd0;
        sum     = elem + rows[lane];
        acc_we  = 1'b0;
        acc_val = sum;
        value   = '0;
        unique case (code)
            2'd0: begin
                if (is_rgb)                  value = elem;
                else if (mode == MODE_OFFSET) value = sum;
                else if (mode == MODE_DIFF) begin
                    value  = sum;
                    acc_we = 1'b1;
                end else                     value = elem;
            end
            2'd1:    value = rows[lane];
            2'd2:    value = cols[cyc];
            default: value = '0;
        endcase
    end
endmodule

// File: rtl/vu_row_bank.sv
module vu_row_bank import vu_pkg::*; (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [LANES-1:0][DW-1:0] load_data,
    input  logic                     upd,
    input  logic [1:0]               upd_lane,
    input  logic [DW-1:0]            upd_data,
    output logic [LANES-1:0][DW-1:0] rows
);
    for (genvar l = 0; l < LANES; l++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n)                             rows[l] <= '0;
            else if (load)                          rows[l] <= load_data[l];
            else if (upd && upd_lane == 2'(l))      rows[l] <= upd_data;
        end
    end

    assert_row_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !upd) |=> $stable(rows));
endmodule

// File: rtl/vupack_mask.sv
module vupack_mask import vu_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       fmt,
    input  logic             mask_en,
    input  logic [1:0]       mode,
    input  logic [31:0]      mask_word,
    input  logic [127:0]     col_regs,
    input  logic             row_wr,
    input  logic [127:0]     row_wdata,
    input  logic             cmd_start,
    input  logic             cmd_fresh,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [127:0]     in_data,
    output logic             out_valid,
    output logic [1:0]       out_lane,
    output logic [31:0]      out_data
);
    shape_e                   shape;
    wid_e                     wid;
    logic                     idle, emit, beat_load;
    logic [1:0]               lane, cyc, code;
    logic [BEAT_W-1:0]        beat_q;
    logic [DW-1:0]            elem, value, acc_val;
    logic                     acc_we;
    logic [LANES-1:0][DW-1:0] rows, cols, row_init;

    always_comb begin
        shape    = shape_e'(fmt[3:2]);
        wid      = wid_e'(fmt[1:0]);
        cols     = col_regs;
        row_init = row_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         beat_q <= '0;
        else if (beat_load) beat_q <= in_data;
    end

    vu_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_fresh(cmd_fresh),
        .cmd_count(cmd_count), .shape(shape), .wid(wid), .in_valid(in_valid),
        .in_ready(in_ready), .idle(idle), .emit(emit), .beat_load(beat_load),
        .lane(lane), .cyc(cyc)
    );

    vu_elem_extract u_ext (
        .beat(beat_q), .shape(shape), .wid(wid), .is_unsigned(fmt[4]),
        .lane(lane), .elem(elem)
    );

    vu_lane_mux u_mux (
        .elem(elem), .lane(lane), .cyc(cyc), .mask_en(mask_en), .mask_word(mask_word),
        .mode(mode), .is_rgb(wid == WID_RGB), .rows(rows), .cols(cols),
        .code(code), .value(value), .acc_we(acc_we), .acc_val(acc_val)
    );

    vu_row_bank u_rows (
        .clk(clk), .rst_n(rst_n), .load(row_wr && idle), .load_data(row_init),
        .upd(emit && acc_we), .upd_lane(lane), .upd_data(acc_val), .rows(rows)
    );

    always_comb begin
        out_valid = emit && (code != 2'd3);
        out_lane  = lane;
        out_data  = value;
    end

    assert_rgb_layout_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && wid == WID_RGB && !mask_en) |-> (out_data[2:0] == 3'd0 && out_data[31:8] == 24'd0));
endmodule

// File: tb/test_vupack_mask.sv
module test_vupack_mask;
    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [4:0]       fmt = '0;
    logic             mask_en = 1'b0;
    logic [1:0]       mode = 2'd0;
    logic [31:0]      mask_word = '0;
    logic [127:0]     col_regs = {32'hC0C3_0003, 32'hC0C2_0002, 32'hC0C1_0001, 32'hC0C0_0000};
    logic             row_wr = 1'b0;
    logic [127:0]     row_wdata = '0;
    logic             cmd_start = 1'b0;
    logic             cmd_fresh = 1'b0;
    logic [CNT_W-1:0] cmd_count = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [127:0]     in_data = '0;
    logic             out_valid;
    logic [1:0]       out_lane;
    logic [31:0]      out_data;

    always #10 clk = ~clk;

    vupack_mask #(.CNT_W(CNT_W)) i_vupack_mask (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .mask_en(mask_en), .mode(mode),
        .mask_word(mask_word), .col_regs(col_regs), .row_wr(row_wr), .row_wdata(row_wdata),
        .cmd_start(cmd_start), .cmd_fresh(cmd_fresh), .cmd_count(cmd_count),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_lane(out_lane), .out_data(out_data)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string cur_req = "R11";

    logic [33:0] exp_q[$];
    int          exp_n, seen_n;
    logic [31:0] m_rows[4];
    int          m_off, m_cyc, m_rem;
    logic [31:0] lcg = 32'h1234_5678;

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: every strobe compared with the model on the cycle it occurs
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            seen_n++;
            if (exp_q.size() == 0) check(1'b0, cur_req, {30'd0, out_lane, out_data}, 64'hDEAD);
            else begin
                logic [33:0] e;
                e = exp_q.pop_front();
                check({out_lane, out_data} == e, cur_req, {30'd0, out_lane, out_data}, {30'd0, e});
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog %s actual=%0d expected=%0d", cur_req, cycles, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [31:0] m_elem(logic [127:0] b, logic [4:0] f, int ln);
        int sh = f[3:2];
        int w  = f[1:0];
        int ix;
        logic [15:0] h;
        logic [7:0]  c;
        if (w == 3) begin
            h = b[15:0];
            if (ln == 0) return 32'(h[4:0]) << 3;
            if (ln == 1) return 32'(h[9:5]) << 3;
            if (ln == 2) return 32'(h[14:10]) << 3;
            return 32'(h[15]) << 7;
        end
        ix = (sh == 0) ? 0 : (sh == 1) ? (ln % 2) : ln;
        if (w == 0) return (sh == 1 && ln == 3) ? 32'd0 : b[ix*32 +: 32];
        if (w == 1) begin
            h = b[ix*16 +: 16];
            return f[4] ? 32'(h) : 32'($signed(h));
        end
        c = b[ix*8 +: 8];
        return f[4] ? 32'(c) : 32'($signed(c));
    endfunction

    function automatic bit m_cons(logic [4:0] f, int ln);
        if (f[1:0] == 2'd3) return 1'b1;
        if (f[3:2] == 2'd1) return ln < 2;
        if (f[3:2] == 2'd2) return ln < 3;
        return 1'b1;
    endfunction

    task automatic model_beat(logic [127:0] b);
        while (1) begin
            bit c;
            logic [1:0] code;
            logic [31:0] e, v;
            c = m_cons(fmt, m_off);
            if (c && m_rem == 0) break;
            if (c) m_rem--;
            code = mask_en ? mask_word[m_cyc*8 + m_off*2 +: 2] : 2'd0;
            e = m_elem(b, fmt, m_off);
            v = e;
            if (code == 2'd0 && fmt[1:0] != 2'd3) begin
                if (mode == 2'd1) v = e + m_rows[m_off];
                else if (mode == 2'd2) begin
                    m_rows[m_off] = e + m_rows[m_off];
                    v = m_rows[m_off];
                end
            end else if (code == 2'd1) v = m_rows[m_off];
            else if (code == 2'd2) v = col_regs[m_cyc*32 +: 32];
            if (code != 2'd3) begin
                exp_q.push_back({2'(m_off), v});
                exp_n++;
            end
            if (m_off == 3) begin
                m_off = 0;
                if (m_cyc < 3) m_cyc++;
                break;
            end
            m_off++;
        end
    endtask

    task automatic load_rows(logic [127:0] r);
        @(negedge clk);
        row_wr = 1'b1; row_wdata = r;
        @(negedge clk);
        row_wr = 1'b0;
        for (int k = 0; k < 4; k++) m_rows[k] = r[k*32 +: 32];
    endtask

    task automatic run(string req, logic [4:0] f, int cnt, bit fresh);
        cur_req = req;
        exp_n = 0; seen_n = 0;
        @(negedge clk);
        fmt = f; cmd_start = 1'b1; cmd_fresh = fresh; cmd_count = CNT_W'(cnt);
        if (fresh) begin m_off = 0; m_cyc = 0; end
        m_rem = cnt;
        @(negedge clk);
        cmd_start = 1'b0;
        while (m_rem > 0) begin
            logic [127:0] b;
            for (int k = 0; k < 4; k++) begin
                lcg = lcg * 32'd1103515245 + 32'd12345;
                b[k*32 +: 32] = lcg ^ {lcg[15:0], lcg[31:16]};
            end
            model_beat(b);
            in_valid = 1'b1; in_data = b;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
        end
        repeat (8) @(negedge clk);
        check(seen_n == exp_n && exp_q.size() == 0, req, 64'(seen_n), 64'(exp_n));
    endtask

    initial begin
        exp_n = 0; seen_n = 0;
        for (int k = 0; k < 4; k++) m_rows[k] = '0;
        m_off = 0; m_cyc = 0; m_rem = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b0 && out_valid == 1'b0, "R11 reset", {in_ready, out_valid}, 64'd0);

        // rows at reset are zero: code 1 on all lanes shows them
        mask_en = 1'b1; mask_word = 32'h5555_5555;
        run("R11 rows after reset", 5'b0_11_00, 4, 1'b1);
        mask_en = 1'b0;

        load_rows({32'h4000_0004, 32'h3000_0003, 32'h2000_0002, 32'h1000_0001});

        run("R12 quad 32", 5'b0_11_00, 8, 1'b1);
        run("R9 quad 16 signed", 5'b0_11_01, 8, 1'b1);
        run("R9 quad 8 unsigned", 5'b1_11_10, 8, 1'b1);
        run("R9 quad 8 signed", 5'b0_11_10, 4, 1'b1);
        run("R12 scalar 16", 5'b0_00_01, 6, 1'b1);
        run("R7 pair 8 signed", 5'b0_01_10, 4, 1'b1);
        run("R7 pair 32", 5'b0_01_00, 2, 1'b1);
        run("R8 triple 16 unsigned", 5'b1_10_01, 6, 1'b1);

        mode = 2'd1;
        run("R4 offset", 5'b0_11_00, 4, 1'b1);
        mode = 2'd2;
        run("R4 difference", 5'b0_11_01, 12, 1'b1);
        run("R5 colour bypass", 5'b0_11_11, 8, 1'b1);
        mode = 2'd0;
        mask_en = 1'b1; mask_word = 32'h5555_5555;
        run("R4 rows after difference", 5'b0_11_00, 4, 1'b1);

        mask_word = 32'hE41B_C639;
        run("R1 R3 R10 masked cycles", 5'b0_11_00, 20, 1'b1);
        mask_en = 1'b0;
        run("R2 mask disabled", 5'b0_11_00, 8, 1'b1);

        run("R6 partial stop", 5'b0_11_00, 2, 1'b1);
        run("R6 resume", 5'b0_11_00, 2, 1'b0);
        run("R7 pair stop at Y", 5'b0_01_01, 1, 1'b1);
        run("R6 pair resume", 5'b0_01_01, 1, 1'b0);

        // row_wr ignored while busy, start with zero count does nothing
        cur_req = "R11 zero count";
        seen_n = 0;
        @(negedge clk);
        cmd_start = 1'b1; cmd_count = '0; cmd_fresh = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        repeat (3) @(negedge clk);
        check(in_ready == 1'b0 && seen_n == 0, "R11 zero count", {in_ready, 31'd0, 32'(seen_n)}, 64'd0);

        mask_en = 1'b1; mask_word = 32'h5555_5555;
        cur_req = "R11 row write while busy";
        @(negedge clk);
        fmt = 5'b0_11_00; cmd_start = 1'b1; cmd_count = CNT_W'(4); cmd_fresh = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0; row_wr = 1'b1; row_wdata = {4{32'hFFFF_FFFF}};
        in_valid = 1'b1; in_data = '0;
        m_off = 0; m_cyc = 0; m_rem = 4; exp_n = 0; seen_n = 0;
        model_beat('0);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        row_wr = 1'b0;
        repeat (6) @(negedge clk);
        check(seen_n == exp_n && exp_q.size() == 0, "R11 row write while busy", 64'(seen_n), 64'(exp_n));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule